// File: doc/BRIEF.md
# I/Q Sample Demultiplexer with Forwarded Data Clock

The block takes one 8-bit I sample and one 8-bit Q sample on every input clock and presents them on parallel output buses, together with a forwarded data clock, a mirrored copy of that clock and an out-of-range flag. In the 1:2 mode, two consecutive samples leave together. The older sample goes on the delayed bus and the newer one on the direct bus, so the downstream logic receives words at half the input rate. In the pass-through mode only the direct bus carries data and the delayed bus is switched off.

The forwarded clock has a fixed relation to the output words. With single data rate, each new word comes with a rising clock edge. With double data rate, each new word comes with either clock edge. When a calibration trim phase is active, the clock is held low and the outputs keep their values. A trim-disable control lets the clock run through every trim after the first one.

Top module: `sample_demux`

## Requirements
- R1: While rst_ni is low, all data outputs, dly_oe_o, ovr_o, dclk_o and dclk2_o are 0. After release, the first sample taken in 1:2 mode goes to the delayed bus.
- R2: In 1:2 mode (demux_en_i=1), on each word load dly_*_o takes the sample captured one input clock before the sample that nd_*_o takes. Both buses change on the same input clock edge.
- R3: In 1:2 mode with ddr_i=0, dclk_o has a period of 2 input clocks and rises on the edge where a new word is loaded.
- R4: In 1:2 mode with ddr_i=1, dclk_o has a period of 4 input clocks. It goes high with one word and low with the next, so a word loads every 2 input clocks.
- R5: In pass-through mode (demux_en_i=0), ddr_i has no effect. Double rate is forced, dclk_o toggles on every input clock starting high, and nd_*_o loads a new sample on every edge.
- R6: In pass-through mode, dly_oe_o is 0 and both delayed buses read 0. In 1:2 mode, dly_oe_o is 1 from the first word load.
- R7: ovr_o is registered together with its word. In 1:2 mode it is the OR of the ovr_i flags of both samples of the pair. In pass-through mode it is the flag of that sample.
- R8: dclk2_o equals dclk_o on every cycle.
- R9: While trim_i is high and the trim is not exempt, dclk_o is held low, the output buses keep their values and the pairing phase restarts. The first sample after the trim goes to the delayed bus.
- R10: After the first trim phase since reset has ended, a trim phase with trim_dis_i=1 is exempt, and the clock and data keep running. The first trim phase is never exempt.
- R11: A change of demux_en_i or ddr_i takes effect only at the end of a full dclk_o period, or directly at the first edge after reset or a trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| samp_i_i | input | 8 | I channel sample |
| samp_q_i | input | 8 | Q channel sample |
| ovr_i | input | 1 | Out-of-range flag for the current sample |
| demux_en_i | input | 1 | 1: 1:2 mode, 0: pass-through |
| ddr_i | input | 1 | 1: double data rate clock, 0: single |
| trim_i | input | 1 | Calibration trim phase active |
| trim_dis_i | input | 1 | Exempt trims after the first from clock gating |
| dly_i_o | output | 8 | Delayed (older) I sample |
| dly_q_o | output | 8 | Delayed (older) Q sample |
| nd_i_o | output | 8 | Direct (newer) I sample |
| nd_q_o | output | 8 | Direct (newer) Q sample |
| dly_oe_o | output | 1 | Output enable of the delayed buses |
| ovr_o | output | 1 | Out-of-range flag of the current word |
| dclk_o | output | 1 | Forwarded data clock |
| dclk2_o | output | 1 | Mirror of the data clock |

## Verification
The sample stream is a counting pattern with distinct I and Q values and a sparse out-of-range flag. A swapped pair order, an off-by-one pairing or a flag taken from the wrong sample therefore shows up as a wrong value. The stream is run in 1:2 single rate, 1:2 double rate, and pass-through with both settings of ddr_i. These runs separate the three clock ratios and show that the rate input is ignored without pairing. A mode switch in the middle of a clock period shows whether the change waits for the period end. A run of three trims (first trim with the exemption bit set, second exempt, third with the bit cleared) shows the difference between a gated trim and an exempt one, and shows the pairing restart after a gated trim.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef struct packed {
    logic demux;
    logic ddr;
  } sdm_cfg_t;

  localparam int unsigned PHW = 2;

  function automatic logic [PHW-1:0] last_phase(sdm_cfg_t c);
    return (c.demux && c.ddr) ? PHW'(3) : PHW'(1);
  endfunction
endpackage

// File: rtl/sdm_timing.sv
module sdm_timing
  import sdm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic demux_en_i,
  input  logic ddr_i,
  input  logic trim_i,
  input  logic trim_dis_i,
  output logic hold_o,
  output logic load_o,
  output logic demux_o,
  output logic dclk_o
);
  logic [PHW-1:0] ph_q, ph_d;
  logic           dclk_q, dclk_d;
  logic           run_q, run_d;
  logic           trim_q, first_done_q;
  sdm_cfg_t       cfg_q, cfg_d, cfg_in, cfg_eff;
  logic           gate, wrap;

  assign gate = trim_i & ~(trim_dis_i & first_done_q);

  always_comb begin
    cfg_in.demux = demux_en_i;
    cfg_in.ddr   = demux_en_i ? ddr_i : 1'b1;  // pass-through is double rate only
    cfg_eff      = run_q ? cfg_q : cfg_in;
    wrap         = (ph_q == last_phase(cfg_eff));
    ph_d   = ph_q;
    dclk_d = dclk_q;
    run_d  = run_q;
    cfg_d  = cfg_q;
    hold_o = 1'b0;
    load_o = 1'b0;
    if (gate) begin
      ph_d   = '0;
      dclk_d = 1'b0;
      run_d  = 1'b0;
    end else begin
      run_d = 1'b1;
      cfg_d = wrap ? cfg_in : cfg_eff;
      ph_d  = wrap ? '0 : ph_q + PHW'(1);
      if (cfg_eff.demux) begin
        hold_o = ~ph_q[0];
        load_o = ph_q[0];
        if (cfg_eff.ddr) begin
          if (ph_q == PHW'(1))      dclk_d = 1'b1;
          else if (ph_q == PHW'(3)) dclk_d = 1'b0;
        end else begin
          dclk_d = (ph_q == PHW'(1));
        end
      end else begin
        load_o = 1'b1;
        dclk_d = (ph_q == '0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q         <= '0;
      dclk_q       <= 1'b0;
      run_q        <= 1'b0;
      cfg_q        <= '0;
      trim_q       <= 1'b0;
      first_done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      dclk_q <= dclk_d;
      run_q  <= run_d;
      cfg_q  <= cfg_d;
      trim_q <= trim_i;
      if (trim_q && !trim_i) first_done_q <= 1'b1;
    end
  end

  assign demux_o = cfg_eff.demux;
  assign dclk_o  = dclk_q;
endmodule

// File: rtl/sdm_lane.sv
module sdm_lane #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         load_i,
  input  logic         demux_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] dly_o,
  output logic [W-1:0] nd_o
);
  logic [W-1:0] hold_q, dly_q, nd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      dly_q  <= '0;
      nd_q   <= '0;
    end else begin
      if (hold_i) hold_q <= d_i;
      if (load_i) begin
        nd_q  <= d_i;
        dly_q <= demux_i ? hold_q : '0;
      end
    end
  end

  assign dly_o = dly_q;
  assign nd_o  = nd_q;
endmodule

// File: rtl/sample_demux.sv
module sample_demux #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] samp_i_i,
  input  logic [DW-1:0] samp_q_i,
  input  logic          ovr_i,
  input  logic          demux_en_i,
  input  logic          ddr_i,
  input  logic          trim_i,
  input  logic          trim_dis_i,
  output logic [DW-1:0] dly_i_o,
  output logic [DW-1:0] dly_q_o,
  output logic [DW-1:0] nd_i_o,
  output logic [DW-1:0] nd_q_o,
  output logic          dly_oe_o,
  output logic          ovr_o,
  output logic          dclk_o,
  output logic          dclk2_o
);
  localparam int unsigned NCH = 2;

  logic hold_w, load_w, demux_w, dclk_w;
  logic [NCH-1:0][DW-1:0] din_w, dly_w, nd_w;
  logic ovr_dly_w, ovr_nd_w;
  logic oe_q;

  sdm_timing u_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .demux_en_i (demux_en_i),
    .ddr_i      (ddr_i),
    .trim_i     (trim_i),
    .trim_dis_i (trim_dis_i),
    .hold_o     (hold_w),
    .load_o     (load_w),
    .demux_o    (demux_w),
    .dclk_o     (dclk_w)
  );

  assign din_w[0] = samp_i_i;
  assign din_w[1] = samp_q_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sdm_lane #(.W(DW)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hold_i  (hold_w),
      .load_i  (load_w),
      .demux_i (demux_w),
      .d_i     (din_w[c]),
      .dly_o   (dly_w[c]),
      .nd_o    (nd_w[c])
    );
  end

  // flag travels through its own 1-bit lane so it stays aligned with its word
  sdm_lane #(.W(1)) u_ovr_lane (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (hold_w),
    .load_i  (load_w),
    .demux_i (demux_w),
    .d_i     (ovr_i),
    .dly_o   (ovr_dly_w),
    .nd_o    (ovr_nd_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     oe_q <= 1'b0;
    else if (load_w) oe_q <= demux_w;
  end

  assign dly_i_o  = dly_w[0];
  assign dly_q_o  = dly_w[1];
  assign nd_i_o   = nd_w[0];
  assign nd_q_o   = nd_w[1];
  assign dly_oe_o = oe_q;
  assign ovr_o    = ovr_dly_w | ovr_nd_w;
  assign dclk_o   = dclk_w;
  assign dclk2_o  = dclk_w;
endmodule

// File: rtl/sample_demux_chk.sv
module sample_demux_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] samp_i_i,
  input logic          ovr_i,
  input logic          load_w,
  input logic          demux_w,
  input logic          trim_i,
  input logic          trim_dis_i,
  input logic [DW-1:0] nd_i_o,
  input logic [DW-1:0] dly_i_o,
  input logic [DW-1:0] dly_q_o,
  input logic          dly_oe_o,
  input logic          dclk_o,
  input logic          ovr_o
);
  p_pair_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w && demux_w |=> nd_i_o == $past(samp_i_i) && dly_i_o == $past(samp_i_i, 2));

  p_pass_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w && !demux_w |=> nd_i_o == $past(samp_i_i) && dly_i_o == '0);

  p_dly_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dly_oe_o |-> dly_i_o == '0 && dly_q_o == '0);

  p_ovr_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w && demux_w |=> ovr_o == ($past(ovr_i) | $past(ovr_i, 2)));

  p_trim_clk_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trim_i && !trim_dis_i |=> !dclk_o);

  p_trim_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trim_i && !trim_dis_i |=> $stable(nd_i_o) && $stable(dly_i_o));
endmodule

bind sample_demux sample_demux_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .samp_i_i   (samp_i_i),
  .ovr_i      (ovr_i),
  .load_w     (load_w),
  .demux_w    (demux_w),
  .trim_i     (trim_i),
  .trim_dis_i (trim_dis_i),
  .nd_i_o     (nd_i_o),
  .dly_i_o    (dly_i_o),
  .dly_q_o    (dly_q_o),
  .dly_oe_o   (dly_oe_o),
  .dclk_o     (dclk_o),
  .ovr_o      (ovr_o)
);

// File: tb/sample_demux_tb_top.sv
`timescale 1ns/1ps
module sample_demux_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] samp_i, samp_q;
  logic ovr_in, demux_en, ddr, trim, trim_dis;
  logic [7:0] dly_i, dly_q, nd_i, nd_q;
  logic dly_oe, ovr_out, dclk, dclk2;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sample_demux dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .samp_i_i(samp_i), .samp_q_i(samp_q),
    .ovr_i(ovr_in), .demux_en_i(demux_en), .ddr_i(ddr), .trim_i(trim),
    .trim_dis_i(trim_dis), .dly_i_o(dly_i), .dly_q_o(dly_q), .nd_i_o(nd_i),
    .nd_q_o(nd_q), .dly_oe_o(dly_oe), .ovr_o(ovr_out), .dclk_o(dclk), .dclk2_o(dclk2)
  );

  function automatic logic [7:0] fi(int n); return 8'(n * 7 + 3); endfunction
  function automatic logic [7:0] fq(int n); return 8'(n * 13) ^ 8'h5A; endfunction
  function automatic logic fo(int n); return (n % 5) == 3; endfunction

  // {dly_i, dly_q, nd_i, nd_q, oe, ovr, dclk, dclk2}
  function automatic logic [35:0] pack(logic [7:0] di, logic [7:0] dq, logic [7:0] ni,
                                       logic [7:0] nq, logic oe, logic ov, logic ck);
    return {di, dq, ni, nq, oe, ov, ck, ck};
  endfunction

  function automatic logic [35:0] exp_pair(int m, logic ck);
    return pack(fi(m - 1), fq(m - 1), fi(m), fq(m), 1'b1, fo(m - 1) | fo(m), ck);
  endfunction

  task automatic chk(string tag, logic [35:0] exp);
    logic [35:0] act;
    act = {dly_i, dly_q, nd_i, nd_q, dly_oe, ovr_out, dclk, dclk2};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // present sample n, then wait past the next rising edge
  task automatic step(int n);
    samp_i = fi(n);
    samp_q = fq(n);
    ovr_in = fo(n);
    @(negedge clk);
  endtask

  task automatic do_reset(logic dm, logic dr);
    rst_ni = 1'b0;
    demux_en = dm; ddr = dr; trim = 1'b0; trim_dis = 1'b0;
    samp_i = 8'hFF; samp_q = 8'hFF; ovr_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset state", '0);
    rst_ni = 1'b1;
  endtask

  task automatic t_mode(logic dm, logic dr, int ncyc, string tag);
    logic [35:0] e;
    do_reset(dm, dr);
    for (int n = 0; n < ncyc; n++) begin
      step(n);
      if (dm) begin
        logic ck;
        ck = dr ? ((n % 4) == 1 || (n % 4) == 2) : ((n % 2) == 1);
        if (n == 0) e = '0;
        else e = exp_pair((n % 2) ? n : n - 1, ck);
      end else begin
        e = pack(8'h0, 8'h0, fi(n), fq(n), 1'b0, fo(n), (n % 2) == 0);
      end
      chk(tag, e);
    end
  endtask

  task automatic t_switch();
    do_reset(1'b1, 1'b1);
    for (int n = 0; n < 5; n++) step(n);
    demux_en = 1'b0; ddr = 1'b0;
    step(5); chk("R11 old mode kept mid period", exp_pair(5, 1'b1));
    step(6); chk("R11 old mode kept mid period", exp_pair(5, 1'b1));
    step(7); chk("R11 last word of old period", exp_pair(7, 1'b0));
    step(8); chk("R11 new mode after boundary",
                 pack(8'h0, 8'h0, fi(8), fq(8), 1'b0, fo(8), 1'b1));
  endtask

  task automatic t_trim();
    do_reset(1'b1, 1'b0);
    for (int n = 0; n < 4; n++) step(n);
    trim = 1'b1; trim_dis = 1'b1;   // first trim: gated despite the disable bit
    for (int n = 4; n < 8; n++) begin
      step(n);
      chk("R9/R10 first trim gated", exp_pair(3, 1'b0));
    end
    trim = 1'b0;
    step(8);
    step(9); chk("R9 pairing restarts after trim", exp_pair(9, 1'b1));
    trim = 1'b1;                    // second trim, exempt
    step(10);
    step(11); chk("R10 exempt trim keeps clock", exp_pair(11, 1'b1));
    step(12); chk("R10 exempt trim keeps clock", exp_pair(11, 1'b0));
    step(13); chk("R10 exempt trim keeps clock", exp_pair(13, 1'b1));
    trim = 1'b0;
    step(14);
    step(15); chk("R3 after exempt trim", exp_pair(15, 1'b1));
    trim = 1'b1; trim_dis = 1'b0;   // disable bit cleared: gated again
    step(16); chk("R9 trim gated", exp_pair(15, 1'b0));
    step(17); chk("R9 trim gated", exp_pair(15, 1'b0));
    trim = 1'b0;
    step(18);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    demux_en = 1'b1; ddr = 1'b0; trim = 1'b0; trim_dis = 1'b0;
    samp_i = '0; samp_q = '0; ovr_in = 1'b0;
    @(negedge clk);
    t_mode(1'b1, 1'b0, 12, "R1/R2/R3/R7/R8 demux single rate");
    t_mode(1'b1, 1'b1, 12, "R2/R4/R6/R7/R8 demux double rate");
    t_mode(1'b0, 1'b1, 10, "R5/R6/R7 pass-through ddr=1");
    t_mode(1'b0, 1'b0, 10, "R5/R6 pass-through ddr ignored");
    t_switch();
    t_trim();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule